// File: doc/BRIEF.md
# Stereo Silence Flag Generator

This block watches a stereo stream of signed audio samples, each pair qualified by a valid strobe. It keeps one run counter per channel. A counter counts consecutive valid samples whose value is exactly zero, and that channel is reported silent once the count reaches a fixed run length of 1024 samples. Any valid nonzero sample restarts the run. Cycles without the strobe leave every counter unchanged.

The two per-channel silence detections feed two flag outputs. Each flag is modelled as an open-drain pin: an output enable that, when high, pulls the pin low, and a drive value that is always low. A two-bit mode chooses the condition behind the flags. A polarity input selects whether the pin pulls low while silence is present or while it is absent. A separate mute request output rises when automatic muting is enabled and both channels are silent. The mode, polarity and auto-mute enable are plain inputs held by surrounding configuration logic, which is expected to hold the mode at 2'b10 and polarity at 0 after reset.

Top module: `zero_flag_unit`

## Requirements
- R1: After reset both run counters are zero, so no channel is silent, both flag enables are low in mode 2'b01 with polarity 0, and the mute request is low.
- R2: A channel becomes silent on the clock edge that accepts its 1024th consecutive valid zero sample, and not after 1023.
- R3: A cycle with the valid strobe low changes neither counter, so gaps inside a run of zeros neither break nor extend it.
- R4: A valid nonzero sample on a channel, including the most negative value, ends that channel's silence on the edge that accepts it and leaves the other channel unaffected.
- R5: A counter holds at the run length, so silence stays reported through any longer run of zeros.
- R6: Mode 2'b00 holds both flag enables low whatever the polarity.
- R7: Mode 2'b01 derives the left flag from left silence and the right flag from right silence.
- R8: Mode 2'b10 derives both flags from the condition that both channels are silent.
- R9: Mode 2'b11 derives both flags from the condition that at least one channel is silent.
- R10: With polarity 0 an enabled flag's output enable is high exactly when its condition holds; with polarity 1 it is high exactly when its condition does not hold.
- R11: Both flag drive outputs are constant low.
- R12: The mute request is high exactly when auto-mute is enabled and both channels are silent, whatever the mode and polarity.
- R13: Changes of mode, polarity or auto-mute enable reach the outputs in the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies the sample pair in this cycle |
| sampleLeft | input | SAMPLE_W | Left channel sample, two's complement |
| sampleRight | input | SAMPLE_W | Right channel sample, two's complement |
| flagMode | input | 2 | 00 off, 01 per channel, 10 both silent, 11 either silent |
| flagInvert | input | 1 | Polarity: 1 reverses the pull-low sense |
| autoMuteEn | input | 1 | Enables the mute request |
| flagLeftOe | output | 1 | Left flag pull-low enable |
| flagRightOe | output | 1 | Right flag pull-low enable |
| flagLeftDrive | output | 1 | Left flag drive value, always 0 |
| flagRightDrive | output | 1 | Right flag drive value, always 0 |
| muteRequest | output | 1 | Auto-mute request to the DAC |

## Verification
Silence status is registered, so the effect of a sample on the flags and the mute request is due one edge after the cycle that presents it; the bench drives each sample just after a falling edge and checks just after the following rising edge. Mode, polarity and auto-mute enable act combinationally, so their effect is checked in the same cycle a short delay after the change. A behavioural model that counts zeros with integers is also compared against every output at each falling edge, when inputs and registers are both settled.

// File: rtl/zfd_pkg.sv
package zfd_pkg;

  typedef enum logic [1:0] {
    FLAG_OFF    = 2'b00,
    FLAG_SPLIT  = 2'b01,
    FLAG_BOTH   = 2'b10,
    FLAG_EITHER = 2'b11
  } flagMode_e;

  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] incRun;
    logic [NUM_CH-1:0] clrRun;
  } runStrobes_t;

endpackage

// File: rtl/zfd_ctrl.sv
module zfd_ctrl
  import zfd_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                             sampleValid,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  samples,
  output runStrobes_t                      strobes
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic isZero;
    assign isZero                = (samples[ch] == '0);
    assign strobes.incRun[ch]    = sampleValid &  isZero;
    assign strobes.clrRun[ch]    = sampleValid & ~isZero;
  end

endmodule

// File: rtl/zfd_datapath.sv
module zfd_datapath
  import zfd_pkg::*;
#(
  parameter int ZERO_RUN = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  runStrobes_t       strobes,
  output logic [NUM_CH-1:0] silent
);

  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ZERO_RUN);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_run
    logic [CNT_W-1:0] runCount;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCount <= '0;
      end else if (strobes.clrRun[ch]) begin
        runCount <= '0;
      end else if (strobes.incRun[ch] && (runCount != RUN_MAX)) begin
        runCount <= runCount + 1'b1;
      end
    end

    assign silent[ch] = (runCount == RUN_MAX);
  end

endmodule

// File: rtl/zfd_flag_decode.sv
module zfd_flag_decode
  import zfd_pkg::*;
(
  input  logic [NUM_CH-1:0] silent,
  input  logic [1:0]        flagMode,
  input  logic              flagInvert,
  input  logic              autoMuteEn,
  output logic [NUM_CH-1:0] flagOe,
  output logic              muteRequest
);

  logic              bothSilent;
  logic              anySilent;
  logic [NUM_CH-1:0] cond;
  logic              enabled;
  flagMode_e         mode;

  assign mode       = flagMode_e'(flagMode);
  assign bothSilent = &silent;
  assign anySilent  = |silent;

  always_comb begin
    enabled = 1'b1;
    unique case (mode)
      FLAG_OFF: begin
        enabled = 1'b0;
        cond    = '0;
      end
      FLAG_SPLIT:  cond = silent;
      FLAG_BOTH:   cond = {NUM_CH{bothSilent}};
      FLAG_EITHER: cond = {NUM_CH{anySilent}};
      default: begin
        enabled = 1'b0;
        cond    = '0;
      end
    endcase
  end

  assign flagOe      = enabled ? (cond ^ {NUM_CH{flagInvert}}) : '0;
  assign muteRequest = autoMuteEn & bothSilent;

endmodule

// File: rtl/zero_flag_unit.sv
module zero_flag_unit
  import zfd_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic [1:0]          flagMode,
  input  logic                flagInvert,
  input  logic                autoMuteEn,
  output logic                flagLeftOe,
  output logic                flagRightOe,
  output logic                flagLeftDrive,
  output logic                flagRightDrive,
  output logic                muteRequest
);

  logic [NUM_CH-1:0][SAMPLE_W-1:0] samples;
  runStrobes_t                     strobes;
  logic [NUM_CH-1:0]               silent;
  logic [NUM_CH-1:0]               flagOe;

  assign samples = {sampleRight, sampleLeft};

  zfd_ctrl #(.SAMPLE_W(SAMPLE_W)) i_ctrl (
    .sampleValid (sampleValid),
    .samples     (samples),
    .strobes     (strobes)
  );

  zfd_datapath #(.ZERO_RUN(ZERO_RUN)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .silent  (silent)
  );

  zfd_flag_decode i_decode (
    .silent      (silent),
    .flagMode    (flagMode),
    .flagInvert  (flagInvert),
    .autoMuteEn  (autoMuteEn),
    .flagOe      (flagOe),
    .muteRequest (muteRequest)
  );

  assign flagLeftOe     = flagOe[0];
  assign flagRightOe    = flagOe[1];
  assign flagLeftDrive  = 1'b0;
  assign flagRightDrive = 1'b0;

endmodule

// File: rtl/zero_flag_unit_checker.sv
module zero_flag_unit_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sampleLeft,
  input logic [SAMPLE_W-1:0] sampleRight,
  input logic [1:0]          flagMode,
  input logic                autoMuteEn,
  input logic                flagLeftOe,
  input logic                flagRightOe,
  input logic                muteRequest,
  input logic [1:0]          silent
);

  // R2: silence can only begin on an edge that accepted a zero sample
  a_r2_rise_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(silent[0]) |-> $past(sampleValid) && ($past(sampleLeft) == '0));

  // R3: no strobe, no change
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(silent));

  // R4: a nonzero left or right sample ends that channel's silence
  a_r4_left_clear: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && (sampleLeft != '0) |=> !silent[0]);
  a_r4_right_clear: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && (sampleRight != '0) |=> !silent[1]);

  // R5: silence persists through further zeros
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rstN)
    silent[1] && sampleValid && (sampleRight == '0) |=> silent[1]);

  // R6: mode off releases both pins
  a_r6_mode_off: assert property (@(posedge clk) disable iff (!rstN)
    (flagMode == 2'b00) |-> !flagLeftOe && !flagRightOe);

  // R12: mute request only with enable and both channels silent
  a_r12_mute_cond: assert property (@(posedge clk) disable iff (!rstN)
    muteRequest |-> autoMuteEn && silent[0] && silent[1]);

endmodule

bind zero_flag_unit zero_flag_unit_checker #(.SAMPLE_W(SAMPLE_W)) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleLeft  (sampleLeft),
  .sampleRight (sampleRight),
  .flagMode    (flagMode),
  .autoMuteEn  (autoMuteEn),
  .flagLeftOe  (flagLeftOe),
  .flagRightOe (flagRightOe),
  .muteRequest (muteRequest),
  .silent      (silent)
);

// File: tb/test_zero_flag_unit.sv
`timescale 1ns/1ps
module test_zero_flag_unit;

  localparam int W   = 24;
  localparam int RUN = 1024;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sampleValid = 1'b0;
  logic [W-1:0] sampleLeft = '0;
  logic [W-1:0] sampleRight = '0;
  logic [1:0]   flagMode = 2'b10;
  logic         flagInvert = 1'b0;
  logic         autoMuteEn = 1'b0;
  logic         flagLeftOe, flagRightOe, flagLeftDrive, flagRightDrive, muteRequest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model
  int runL = 0;
  int runR = 0;

  zero_flag_unit #(.SAMPLE_W(W), .ZERO_RUN(RUN)) i_zero_flag_unit (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .flagMode(flagMode), .flagInvert(flagInvert), .autoMuteEn(autoMuteEn),
    .flagLeftOe(flagLeftOe), .flagRightOe(flagRightOe),
    .flagLeftDrive(flagLeftDrive), .flagRightDrive(flagRightDrive),
    .muteRequest(muteRequest)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      runL = 0;
      runR = 0;
    end else if (sampleValid) begin
      runL = (sampleLeft  == 0) ? ((runL < RUN) ? runL + 1 : RUN) : 0;
      runR = (sampleRight == 0) ? ((runR < RUN) ? runR + 1 : RUN) : 0;
    end
  end

  function automatic void expectedFlags(output bit eL, output bit eR, output bit eM);
    bit sL, sR, cL, cR;
    sL = (runL >= RUN);
    sR = (runR >= RUN);
    case (flagMode)
      2'b01:   begin cL = sL;      cR = sR;      end
      2'b10:   begin cL = sL & sR; cR = sL & sR; end
      2'b11:   begin cL = sL | sR; cR = sL | sR; end
      default: begin cL = 1'b0;    cR = 1'b0;    end
    endcase
    if (flagMode == 2'b00) begin
      eL = 1'b0; eR = 1'b0;
    end else begin
      eL = cL ^ flagInvert; eR = cR ^ flagInvert;
    end
    eM = autoMuteEn & sL & sR;
  endfunction

  function automatic string modeTag();
    if (flagMode == 2'b00) return "R6";
    if (flagInvert)        return "R10";
    case (flagMode)
      2'b01:   return "R7";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    bit eL, eR, eM;
    if (rstN && !done) begin
      expectedFlags(eL, eR, eM);
      check(modeTag(), {flagLeftOe, flagRightOe}, {eL, eR});
      check("R12", muteRequest, eM);
      check("R11", {flagLeftDrive, flagRightDrive}, 0);
    end
  end

  task automatic push(bit v, logic [W-1:0] l, logic [W-1:0] r);
    @(negedge clk); #2;
    sampleValid = v; sampleLeft = l; sampleRight = r;
    @(posedge clk); #1;
  endtask

  task automatic pushMany(int n, logic [W-1:0] l, logic [W-1:0] r);
    for (int i = 0; i < n; i++) push(1'b1, l, r);
  endtask

  task automatic setCfg(logic [1:0] m, bit inv, bit en);
    @(negedge clk); #2;
    flagMode = m; flagInvert = inv; autoMuteEn = en; sampleValid = 1'b0;
    #1;
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    setCfg(2'b01, 1'b0, 1'b1);
    // R1: released after reset
    check("R1 flags", {flagLeftOe, flagRightOe}, 0);
    check("R1 mute", muteRequest, 0);

    // R2: 1023 zeros not enough, 1024th asserts
    pushMany(RUN - 1, '0, '0);
    check("R2 early", {flagLeftOe, flagRightOe}, 0);
    push(1'b1, '0, '0);
    check("R2 reached", {flagLeftOe, flagRightOe}, 3);
    check("R12 mute on", muteRequest, 1);

    // R3: idle cycles hold
    repeat (5) push(1'b0, 24'h5, 24'h7);
    check("R3 idle hold", {flagLeftOe, flagRightOe}, 3);

    // R5: longer silence keeps flags
    pushMany(2000, '0, '0);
    check("R5 saturate", {flagLeftOe, flagRightOe}, 3);

    // R4 / R7: left breaks with smallest nonzero value
    push(1'b1, 24'h1, '0);
    check("R4 left clear", flagLeftOe, 0);
    check("R7 right kept", flagRightOe, 1);
    check("R12 mute off", muteRequest, 0);

    // R8, R9, R10, R6, R13 on the current state (left active, right silent)
    setCfg(2'b10, 1'b0, 1'b1);
    check("R8 both", {flagLeftOe, flagRightOe}, 0);
    check("R13 same cycle", {flagLeftOe, flagRightOe}, 0);
    setCfg(2'b11, 1'b0, 1'b1);
    check("R9 either", {flagLeftOe, flagRightOe}, 3);
    setCfg(2'b11, 1'b1, 1'b1);
    check("R10 invert", {flagLeftOe, flagRightOe}, 0);
    setCfg(2'b10, 1'b1, 1'b1);
    check("R10 invert both", {flagLeftOe, flagRightOe}, 3);
    setCfg(2'b00, 1'b1, 1'b1);
    check("R6 off inv", {flagLeftOe, flagRightOe}, 0);
    setCfg(2'b00, 1'b0, 1'b1);
    check("R6 off", {flagLeftOe, flagRightOe}, 0);

    // R3: left run with gaps in the strobe
    setCfg(2'b01, 1'b0, 1'b1);
    for (int i = 0; i < RUN - 1; i++) begin
      push(1'b1, '0, '0);
      if (i % 7 == 0) push(1'b0, 24'h123, 24'h456);
    end
    check("R3 gaps no early", flagLeftOe, 0);
    push(1'b1, '0, '0);
    check("R3 gaps reach", flagLeftOe, 1);
    check("R12 both again", muteRequest, 1);

    // R12: independence from mode and polarity, and enable gating
    setCfg(2'b00, 1'b1, 1'b1);
    check("R12 mode off", muteRequest, 1);
    setCfg(2'b00, 1'b1, 1'b0);
    check("R12 disabled", muteRequest, 0);

    // R4: right breaks with most negative value
    setCfg(2'b01, 1'b0, 1'b1);
    push(1'b1, '0, 24'h800000);
    check("R4 right clear", {flagLeftOe, flagRightOe}, 2);
    check("R4 mute drop", muteRequest, 0);

    // R1: reset mid-run clears silence
    @(negedge clk); #2 rstN = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    #1;
    check("R1 reset clears", {flagLeftOe, flagRightOe, muteRequest}, 0);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule